// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns parallel stereo sample words into a one-wire serial stream for an external receiver. It is a clock slave. The bit clock and the frame clock come from outside and are sampled in the block's own system clock domain. Each time the frame clock changes level, the block takes the word for the channel that is starting. It then shifts that word out, most significant bit first, one bit for each falling edge of the bit clock. The receiver samples each bit on the rising edge.

A two-bit format code sets the framing. The three lower codes give MSB-justified framing: the first data bit follows the frame edge at once, and a high frame clock means the left channel. The top code gives I2S framing: one idle bit comes before the first data bit, and a low frame clock means the left channel. The sample width is 20 bits by default. The block works with a bit clock of 32 or 64 times the frame rate. With 32x, the low bits that do not fit in a 16-bit slot are lost. With 64x, the slot is filled with zeros after the data. The block pulses a request strobe once after each frame edge, so that the source can present the next word.

Top module: `aud_ser_tx`

## Requirements
- R1: For `fmt` codes 00, 01 and 10, the bit sent in slot position k (k=0 at the frame edge) is bit 19-k of the latched two's-complement word, so the MSB goes out first.
- R2: For `fmt` code 11, slot position 0 sends 0, and position k≥1 sends bit 20-k of the latched word.
- R3: For codes 00, 01 and 10, a slot that starts when `lrclk` goes high takes `left_word`. A slot that starts when `lrclk` goes low takes `right_word`.
- R4: For code 11, a slot that starts when `lrclk` goes low takes `left_word`. A slot that starts when `lrclk` goes high takes `right_word`.
- R5: `sdata` changes only in the cycle that comes SYNC_STAGES+1 system clocks after a falling edge of `bclk` is applied.
- R6: With a 32x bit clock (16 positions per slot), the next frame edge drops the unsent low bits of the word: 4 bits in the MSB-justified formats and 5 bits in I2S.
- R7: With a 64x bit clock, every position after the last data bit and before the next frame edge sends 0.
- R8: After reset, `sdata` stays 0 until the first change of `lrclk` is seen on a `bclk` falling edge.
- R9: `sample_req` is high for exactly one system clock, one cycle after each detected frame edge. It pulses once for each frame edge.
- R10: While reset is held, `sdata` and `sample_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | External bit clock |
| lrclk | input | 1 | External frame (channel) clock |
| fmt | input | 2 | Framing code: 00/01/10 MSB-justified, 11 I2S |
| left_word | input | DATA_W | Left-channel sample, two's complement |
| right_word | input | DATA_W | Right-channel sample, two's complement |
| sample_req | output | 1 | One-cycle pulse after each frame edge |
| sdata | output | 1 | Serial data out |

## Verification
The assertions check four properties on every cycle. The output moves only after a detected bit-clock fall. It stays zero before lock. The request strobe is a single-cycle pulse that follows a frame edge. I2S inserts an idle bit at each frame edge. Other properties need whole frames of traffic from the bench scenarios: correct bit order, left/right polarity for each format code, the bits lost at a 32x bit clock, and the zero padding at 64x.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
   typedef enum logic [1:0] {
      FMT_MJ_A = 2'b00,
      FMT_MJ_B = 2'b01,
      FMT_MJ_C = 2'b10,
      FMT_I2S  = 2'b11
   } tx_fmt_e;

   function automatic logic fmt_is_i2s(input logic [1:0] code);
      return code == FMT_I2S;
   endfunction
endpackage

// File: rtl/sertx_sync.sv
module sertx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 0) begin : g_bad
      $error("sertx_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign dout = din;
   end else begin : g_chain
      logic [STAGES:1] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            chain <= '0;
         end else begin
            chain[1] <= din;
            for (int i = 1; i < STAGES; i++) chain[i+1] <= chain[i];
         end
      end
      assign dout = chain[STAGES];
   end
endmodule

// File: rtl/sertx_edge.sv
module sertx_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_s,
   input  logic lr_s,
   output logic fall_evt,
   output logic frame_edge,
   output logic locked
);
   logic bclk_q;
   logic lr_last;
   logic seen;

   assign fall_evt   = bclk_q & ~bclk_s;
   assign frame_edge = fall_evt & seen & (lr_s != lr_last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bclk_q  <= 1'b0;
         lr_last <= 1'b0;
         seen    <= 1'b0;
         locked  <= 1'b0;
      end else begin
         bclk_q <= bclk_s;
         if (fall_evt) begin
            lr_last <= lr_s;
            seen    <= 1'b1;
         end
         if (frame_edge) locked <= 1'b1;
      end
   end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
   parameter int DATA_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall_evt,
   input  logic              frame_edge,
   input  logic              locked,
   input  logic              i2s,
   input  logic [DATA_W-1:0] load_word,
   output logic              sdata
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] shreg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '0;
         sdata <= 1'b0;
      end else if (fall_evt) begin
         if (frame_edge) begin
            if (i2s) begin
               sdata <= 1'b0;
               shreg <= load_word;
            end else begin
               sdata <= load_word[MSB];
               shreg <= {load_word[MSB-1:0], 1'b0};
            end
         end else if (locked) begin
            sdata <= shreg[MSB];
            shreg <= {shreg[MSB-1:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
   import aud_tx_pkg::*;
#(
   parameter int DATA_W      = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk,
   input  logic              lrclk,
   input  logic [1:0]        fmt,
   input  logic [DATA_W-1:0] left_word,
   input  logic [DATA_W-1:0] right_word,
   output logic              sample_req,
   output logic              sdata
);
   if (DATA_W < 2) begin : g_bad_w
      $error("aud_ser_tx: DATA_W must be at least 2");
   end

   logic bclk_s, lr_s;
   logic fall_evt, frame_edge, locked;
   logic i2s, left_start;
   logic [DATA_W-1:0] load_word;

   sertx_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
      .clk(clk), .rst_n(rst_n), .din(bclk), .dout(bclk_s));
   sertx_sync #(.STAGES(SYNC_STAGES)) u_sync_f (
      .clk(clk), .rst_n(rst_n), .din(lrclk), .dout(lr_s));

   sertx_edge u_edge (
      .clk(clk), .rst_n(rst_n), .bclk_s(bclk_s), .lr_s(lr_s),
      .fall_evt(fall_evt), .frame_edge(frame_edge), .locked(locked));

   assign i2s        = fmt_is_i2s(fmt);
   assign left_start = i2s ? ~lr_s : lr_s;
   assign load_word  = left_start ? left_word : right_word;

   sertx_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt),
      .frame_edge(frame_edge), .locked(locked), .i2s(i2s),
      .load_word(load_word), .sdata(sdata));

   always_ff @(posedge clk) begin
      if (!rst_n) sample_req <= 1'b0;
      else        sample_req <= frame_edge;
   end
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       fall_evt,
   input logic       frame_edge,
   input logic       locked,
   input logic [1:0] fmt,
   input logic       sdata,
   input logic       sample_req
);
   assert_sdata_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdata) |-> $past(fall_evt));

   assert_req_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sample_req |=> !sample_req);

   assert_req_after_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sample_req |-> $past(frame_edge));

   assert_quiet_before_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> !sdata);

   assert_i2s_gap_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_edge && fmt == 2'b11) |=> !sdata);
endmodule

bind aud_ser_tx sertx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .frame_edge(frame_edge),
   .locked(locked), .fmt(fmt), .sdata(sdata), .sample_req(sample_req));

// File: tb/aud_ser_tx_test.sv
module aud_ser_tx_test;
   localparam int W = 20;
   localparam int HALF = 6;

   typedef struct {
      logic  val;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk = 1'b1;
   logic lrclk = 1'b0;
   logic [1:0] fmt = 2'b00;
   logic [W-1:0] left_word = '0;
   logic [W-1:0] right_word = '0;
   logic sample_req, sdata;

   int total = 0;
   int bad = 0;
   int req_cnt = 0;
   logic mon_en = 1'b0;
   exp_t q[$];

   always #5 clk = ~clk;

   aud_ser_tx #(.DATA_W(W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .fmt(fmt),
      .left_word(left_word), .right_word(right_word),
      .sample_req(sample_req), .sdata(sdata));

   task automatic check(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic check_int(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic exp_bit(input logic [W-1:0] w, input int k, input logic i2s);
      int idx;
      idx = i2s ? (W - k) : (W - 1 - k);
      if (i2s && k == 0) return 1'b0;
      if (idx < 0) return 1'b0;
      return w[idx];
   endfunction

   // monitor: compare serial bits at each bit-clock rising edge
   always @(posedge bclk) begin
      #1;
      if (mon_en) begin
         if (q.size() == 0) begin
            check("R5 unexpected bit", sdata, 1'b0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, sdata, e.val);
         end
      end
   end

   always @(negedge clk) if (mon_en && sample_req) req_cnt++;

   task automatic set_word(input logic [1:0] f, input logic lvl, input logic [W-1:0] w);
      logic left;
      left = fmt_left(f, lvl);
      if (left) left_word = w;
      else      right_word = w;
   endtask

   function automatic logic fmt_left(input logic [1:0] f, input logic lvl);
      return (f == 2'b11) ? ~lvl : lvl;
   endfunction

   task automatic run(input logic [1:0] f, input int n, input logic lr0, input int nslots);
      logic i2s;
      logic [W-1:0] w;
      logic [W-1:0] nxt;
      string tg;
      i2s = (f == 2'b11);
      @(negedge clk);
      rst_n = 1'b0; fmt = f; lrclk = lr0; bclk = 1'b1; mon_en = 1'b0;
      repeat (3) @(negedge clk);
      check("R10 sdata in reset", sdata, 1'b0);
      check("R10 sample_req in reset", sample_req, 1'b0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      req_cnt = 0;
      q.delete();
      mon_en = 1'b1;
      nxt = W'($urandom) | (W'(1) << (W - 1));
      for (int s = 0; s < nslots; s++) begin
         logic lvl;
         lvl = lr0 ^ s[0];
         w = nxt;
         if (s == 1) set_word(f, lvl, w);
         for (int k = 0; k < n; k++) begin
            exp_t e;
            if (s == 0) begin
               e.val = 1'b0; e.tag = "R8 pre-lock";
            end else begin
               e.val = exp_bit(w, k, i2s);
               if (n == 16 && k == n - 1) tg = "R6 truncated slot";
               else if ((i2s && k > W) || (!i2s && k >= W)) tg = "R7 zero pad";
               else if (i2s && fmt_left(f, lvl)) tg = "R2 R4 left";
               else if (i2s) tg = "R2 R4 right";
               else if (fmt_left(f, lvl)) tg = "R1 R3 left";
               else tg = "R1 R3 right";
               e.tag = tg;
            end
            q.push_back(e);
         end
         for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bclk = 1'b0;
            if (k == 0) lrclk = lvl;
            repeat (HALF) @(negedge clk);
            bclk = 1'b1;
            if (k == n / 2) begin
               nxt = W'($urandom);
               set_word(f, ~lvl, nxt);
            end
            repeat (HALF - 1) @(negedge clk);
         end
      end
      @(negedge clk);
      bclk = 1'b0;
      repeat (HALF) @(negedge clk);
      mon_en = 1'b0;
      check_int("R9 request pulse count", req_cnt, nslots - 1);
      check_int("R5 bits left unchecked", q.size(), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      for (int f = 0; f < 4; f++) begin
         run(2'(f), 32, 1'(f), 6);
         run(2'(f), 16, ~1'(f), 6);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule